// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This unit holds a small bank of 32-bit core control and status registers and decides the outcome of every access to them. The core has a read port that works in any privilege mode and a write port that checks privilege. A write from a non-supervisor mode raises a trap. A supervisor write that cannot land is dropped without a trap and reported as having no effect. A write that passes every check is committed on the next rising clock edge. The decisions on the write port are taken in a fixed order: privilege first, then word alignment, then whether the target is read-only, then whether it is implemented.

A separate debug port reaches the same registers through a memory-mapped window. It skips the privilege check and flags misaligned offsets with an error. The core's ordinary memory path is not allowed into that window, so any core memory access that lands in it is refused. The status word at offset 0x0000 carries overflow flags. A dedicated clear operation, allowed in every mode, resets only those flags.

Top module: `creg_access_unit`

## Requirements
- R1: A core read with `coreRdEn` high, in any `privMode` (2'b00 User-0, 2'b01 User-1, 2'b10 Supervisor, 2'b11 reserved), returns the register at an aligned implemented offset on `coreRdData` in the same cycle and never raises `coreTrap` or `coreNoEffect`.
- R2: A core write with `privMode` other than 2'b10 pulses `coreTrap` in the same cycle, does not pulse `coreNoEffect`, and changes no register.
- R3: A Supervisor write to an aligned, implemented, writable offset is committed at the next rising edge, with neither `coreTrap` nor `coreNoEffect`.
- R4: A Supervisor write is dropped with a `coreNoEffect` pulse and no trap in three cases: when the offset has a nonzero value in bits [1:0], when it is read-only (default: offset 0x0004), or when it is unimplemented (default: offsets 0x0020 and above). Checks run in the order privilege, alignment, read-only, implemented.
- R5: A core read of a misaligned or unimplemented offset returns 32'h0000_0000 with no trap. When `coreRdEn` is low, `coreRdData` is also zero.
- R6: `ovfClr` clears bits [31:27] of the status word at offset 0x0000 at the next edge. It leaves bits [26:0] unchanged and is accepted in every privilege mode.
- R7: When a Supervisor write to offset 0x0000 and `ovfClr` occur in the same cycle, the status word becomes the written value with bits [31:27] cleared.
- R8: A core memory access with `coreMemEn` high and `coreMemAddr` in 0xF000_0000 to 0xF000_FFFF pulses `coreMemRefuse` in the same cycle and changes no register. Addresses outside that range do not pulse it.
- R9: The debug port ignores `privMode`. It reads and writes aligned implemented offsets, ignores writes to read-only or unimplemented offsets, and for a misaligned offset pulses `dbgErr`, writes nothing and returns zero read data.
- R10: If a debug write and a committing core write target the same register in one cycle, the core data is stored.
- R11: After reset, every writable register holds zero. A read-only register reads as 32'hA5C3_0000 ORed with its word index, so offset 0x0004 reads 32'hA5C3_0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| privMode | input | 2 | Current privilege mode of the core |
| coreRdEn | input | 1 | Core move-from-register strobe |
| coreRdOfs | input | 16 | Register offset for the core read |
| coreRdData | output | 32 | Core read data, zero when undefined |
| coreWrEn | input | 1 | Core move-to-register strobe |
| coreWrOfs | input | 16 | Register offset for the core write |
| coreWrData | input | 32 | Core write source data |
| coreTrap | output | 1 | Privilege trap pulse for the core write |
| coreNoEffect | output | 1 | Pulse for a dropped privileged write |
| ovfClr | input | 1 | Clear overflow flags in the status word |
| coreMemEn | input | 1 | Core ordinary memory access strobe |
| coreMemAddr | input | 32 | Core ordinary memory address |
| coreMemRefuse | output | 1 | Memory access refused: it hits the register window |
| dbgEn | input | 1 | Debug access strobe |
| dbgWe | input | 1 | Debug write when high, read when low |
| dbgOfs | input | 16 | Offset inside the register window |
| dbgWrData | input | 32 | Debug write data |
| dbgRdData | output | 32 | Debug read data |
| dbgErr | output | 1 | Debug misaligned-offset error pulse |

## Verification
The assertions that check a register bank stays stable after a trap, a dropped write or a refused memory access assume that no other writer acts in that cycle. For this reason each of them is qualified on the absence of a debug write, an overflow clear and, for the refusal case, a core write. The stimulus issues those events both alone and mixed, so the qualified cases do occur. The read-data assertions assume the strobes are driven with known values away from the clock edge. The bench drives every input at the falling edge, from directed sequences and from a bounded random mix of offsets that covers the misaligned, read-only and unimplemented cases.

// File: rtl/creg_pkg.sv
package creg_pkg;
  localparam int OFS_W  = 16;
  localparam int IDX_W  = OFS_W - 2;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    PRIV_USER0 = 2'b00,
    PRIV_USER1 = 2'b01,
    PRIV_SUPER = 2'b10,
    PRIV_RSVD  = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_TRAP,
    WR_IGNORE,
    WR_COMMIT
  } wr_outcome_e;

  typedef struct packed {
    logic             coreWr;
    logic [IDX_W-1:0] coreWrIdx;
    logic             dbgWr;
    logic [IDX_W-1:0] dbgWrIdx;
    logic             ovfClr;
    logic             coreRdOk;
    logic [IDX_W-1:0] coreRdIdx;
    logic             dbgRdOk;
    logic [IDX_W-1:0] dbgRdIdx;
  } strobes_t;
endpackage

// File: rtl/creg_ctrl.sv
module creg_ctrl
  import creg_pkg::*;
#(
  parameter int                  SLOTS     = 16,
  parameter logic [SLOTS-1:0]    IMPL_MASK = 16'h00FF,
  parameter logic [SLOTS-1:0]    RO_MASK   = 16'h0002,
  parameter logic [DATA_W-1:0]   WIN_BASE  = 32'hF000_0000,
  parameter int                  WIN_BITS  = 16
) (
  input  logic [1:0]        privMode,
  input  logic              coreRdEn,
  input  logic [OFS_W-1:0]  coreRdOfs,
  input  logic              coreWrEn,
  input  logic [OFS_W-1:0]  coreWrOfs,
  output logic              coreTrap,
  output logic              coreNoEffect,
  input  logic              ovfClr,
  input  logic              coreMemEn,
  input  logic [DATA_W-1:0] coreMemAddr,
  output logic              coreMemRefuse,
  input  logic              dbgEn,
  input  logic              dbgWe,
  input  logic [OFS_W-1:0]  dbgOfs,
  output logic              dbgErr,
  output strobes_t          strb
);
  localparam logic [DATA_W-1:0] WIN_LOW  = DATA_W'((64'd1 << WIN_BITS) - 64'd1);
  localparam logic [DATA_W-1:0] WIN_MASK = ~WIN_LOW;

  function automatic logic isAligned(logic [OFS_W-1:0] ofs);
    return ofs[1:0] == 2'b00;
  endfunction

  function automatic logic maskBit(logic [SLOTS-1:0] mask, logic [OFS_W-1:0] ofs);
    logic [IDX_W-1:0] idx;
    logic [SLOTS-1:0] sh;
    idx = ofs[OFS_W-1:2];
    sh  = mask >> idx;
    return (idx < IDX_W'(SLOTS)) && sh[0];
  endfunction

  wr_outcome_e coreOutcome;
  logic        isSuper;

  always_comb begin
    isSuper = priv_e'(privMode) == PRIV_SUPER;
    if (!coreWrEn)                           coreOutcome = WR_NONE;
    else if (!isSuper)                       coreOutcome = WR_TRAP;
    else if (!isAligned(coreWrOfs))          coreOutcome = WR_IGNORE;
    else if (maskBit(RO_MASK, coreWrOfs))    coreOutcome = WR_IGNORE;
    else if (!maskBit(IMPL_MASK, coreWrOfs)) coreOutcome = WR_IGNORE;
    else                                     coreOutcome = WR_COMMIT;
  end

  assign coreTrap     = coreOutcome == WR_TRAP;
  assign coreNoEffect = coreOutcome == WR_IGNORE;

  assign coreMemRefuse = coreMemEn && ((coreMemAddr & WIN_MASK) == (WIN_BASE & WIN_MASK));

  assign dbgErr = dbgEn && !isAligned(dbgOfs);

  always_comb begin
    strb.coreWr    = coreOutcome == WR_COMMIT;
    strb.coreWrIdx = coreWrOfs[OFS_W-1:2];
    strb.dbgWr     = dbgEn && dbgWe && isAligned(dbgOfs)
                     && maskBit(IMPL_MASK, dbgOfs) && !maskBit(RO_MASK, dbgOfs);
    strb.dbgWrIdx  = dbgOfs[OFS_W-1:2];
    strb.ovfClr    = ovfClr;
    strb.coreRdOk  = coreRdEn && isAligned(coreRdOfs) && maskBit(IMPL_MASK, coreRdOfs);
    strb.coreRdIdx = coreRdOfs[OFS_W-1:2];
    strb.dbgRdOk   = dbgEn && !dbgWe && isAligned(dbgOfs) && maskBit(IMPL_MASK, dbgOfs);
    strb.dbgRdIdx  = dbgOfs[OFS_W-1:2];
  end
endmodule

// File: rtl/creg_dpath.sv
module creg_dpath
  import creg_pkg::*;
#(
  parameter int                SLOTS       = 16,
  parameter logic [SLOTS-1:0]  IMPL_MASK   = 16'h00FF,
  parameter logic [SLOTS-1:0]  RO_MASK     = 16'h0002,
  parameter int                STATUS_SLOT = 0,
  parameter logic [DATA_W-1:0] OVF_MASK    = 32'hF800_0000,
  parameter logic [DATA_W-1:0] RO_BASE     = 32'hA5C3_0000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     strb,
  input  logic [DATA_W-1:0]            coreWrData,
  input  logic [DATA_W-1:0]            dbgWrData,
  output logic [DATA_W-1:0]            coreRdData,
  output logic [DATA_W-1:0]            dbgRdData,
  output logic [SLOTS-1:0][DATA_W-1:0] regBank
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    if (IMPL_MASK[i] && !RO_MASK[i]) begin : g_rw
      logic [DATA_W-1:0] nxt;
      always_comb begin
        nxt = regBank[i];
        if (strb.dbgWr && strb.dbgWrIdx == MY_IDX)   nxt = dbgWrData;
        if (strb.coreWr && strb.coreWrIdx == MY_IDX) nxt = coreWrData;
        if (i == STATUS_SLOT && strb.ovfClr)         nxt = nxt & ~OVF_MASK;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regBank[i] <= '0;
        else       regBank[i] <= nxt;
      end
    end else if (IMPL_MASK[i]) begin : g_ro
      assign regBank[i] = RO_BASE | DATA_W'(i);
    end else begin : g_none
      assign regBank[i] = '0;
    end
  end

  always_comb begin
    coreRdData = '0;
    dbgRdData  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (strb.coreRdOk && strb.coreRdIdx == IDX_W'(s)) coreRdData = regBank[s];
      if (strb.dbgRdOk && strb.dbgRdIdx == IDX_W'(s))   dbgRdData  = regBank[s];
    end
  end
endmodule

// File: rtl/creg_access_unit.sv
module creg_access_unit
  import creg_pkg::*;
#(
  parameter int                SLOTS       = 16,
  parameter logic [SLOTS-1:0]  IMPL_MASK   = 16'h00FF,
  parameter logic [SLOTS-1:0]  RO_MASK     = 16'h0002,
  parameter int                STATUS_SLOT = 0,
  parameter logic [DATA_W-1:0] OVF_MASK    = 32'hF800_0000,
  parameter logic [DATA_W-1:0] RO_BASE     = 32'hA5C3_0000,
  parameter logic [DATA_W-1:0] WIN_BASE    = 32'hF000_0000,
  parameter int                WIN_BITS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        privMode,
  input  logic              coreRdEn,
  input  logic [OFS_W-1:0]  coreRdOfs,
  output logic [DATA_W-1:0] coreRdData,
  input  logic              coreWrEn,
  input  logic [OFS_W-1:0]  coreWrOfs,
  input  logic [DATA_W-1:0] coreWrData,
  output logic              coreTrap,
  output logic              coreNoEffect,
  input  logic              ovfClr,
  input  logic              coreMemEn,
  input  logic [DATA_W-1:0] coreMemAddr,
  output logic              coreMemRefuse,
  input  logic              dbgEn,
  input  logic              dbgWe,
  input  logic [OFS_W-1:0]  dbgOfs,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  output logic              dbgErr
);
  strobes_t                     strb;
  logic [SLOTS-1:0][DATA_W-1:0] regBank;

  creg_ctrl #(
    .SLOTS(SLOTS), .IMPL_MASK(IMPL_MASK), .RO_MASK(RO_MASK),
    .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS)
  ) u_ctrl (
    .privMode(privMode), .coreRdEn(coreRdEn), .coreRdOfs(coreRdOfs),
    .coreWrEn(coreWrEn), .coreWrOfs(coreWrOfs),
    .coreTrap(coreTrap), .coreNoEffect(coreNoEffect), .ovfClr(ovfClr),
    .coreMemEn(coreMemEn), .coreMemAddr(coreMemAddr), .coreMemRefuse(coreMemRefuse),
    .dbgEn(dbgEn), .dbgWe(dbgWe), .dbgOfs(dbgOfs), .dbgErr(dbgErr), .strb(strb)
  );

  creg_dpath #(
    .SLOTS(SLOTS), .IMPL_MASK(IMPL_MASK), .RO_MASK(RO_MASK),
    .STATUS_SLOT(STATUS_SLOT), .OVF_MASK(OVF_MASK), .RO_BASE(RO_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .coreWrData(coreWrData), .dbgWrData(dbgWrData),
    .coreRdData(coreRdData), .dbgRdData(dbgRdData), .regBank(regBank)
  );
endmodule

// File: rtl/creg_access_checker.sv
module creg_access_checker
  import creg_pkg::*;
#(
  parameter int                SLOTS       = 16,
  parameter int                STATUS_SLOT = 0,
  parameter logic [DATA_W-1:0] OVF_MASK    = 32'hF800_0000
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [1:0]                   privMode,
  input logic                         coreRdEn,
  input logic [1:0]                   coreRdLow,
  input logic [DATA_W-1:0]            coreRdData,
  input logic                         coreWrEn,
  input logic                         coreTrap,
  input logic                         coreNoEffect,
  input logic                         ovfClr,
  input logic                         coreMemRefuse,
  input logic                         dbgEn,
  input logic                         dbgWe,
  input logic [1:0]                   dbgLow,
  input logic                         dbgErr,
  input logic [DATA_W-1:0]            dbgRdData,
  input logic [SLOTS-1:0][DATA_W-1:0] regBank
);
  logic dbgWrAny;
  assign dbgWrAny = dbgEn && dbgWe;

  AST_USER_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    coreWrEn && privMode != 2'b10 |-> coreTrap && !coreNoEffect); // R2

  AST_TRAP_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    coreTrap && !dbgWrAny && !ovfClr |=> $stable(regBank)); // R2

  AST_NO_FLAG_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !coreWrEn |-> !coreTrap && !coreNoEffect); // R1

  AST_IGNORE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    coreNoEffect && !dbgWrAny && !ovfClr |=> $stable(regBank)); // R4

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    coreRdEn && coreRdLow != 2'b00 |-> coreRdData == '0); // R5

  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ovfClr |=> (regBank[STATUS_SLOT] & OVF_MASK) == '0); // R6

  AST_REFUSE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    coreMemRefuse && !coreWrEn && !dbgWrAny && !ovfClr |=> $stable(regBank)); // R8

  AST_DBG_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (!rstN)
    dbgEn && dbgLow != 2'b00 |-> dbgErr && dbgRdData == '0); // R9
endmodule

bind creg_access_unit creg_access_checker #(
  .SLOTS(SLOTS), .STATUS_SLOT(STATUS_SLOT), .OVF_MASK(OVF_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .privMode(privMode), .coreRdEn(coreRdEn),
  .coreRdLow(coreRdOfs[1:0]), .coreRdData(coreRdData), .coreWrEn(coreWrEn),
  .coreTrap(coreTrap), .coreNoEffect(coreNoEffect), .ovfClr(ovfClr),
  .coreMemRefuse(coreMemRefuse), .dbgEn(dbgEn), .dbgWe(dbgWe),
  .dbgLow(dbgOfs[1:0]), .dbgErr(dbgErr), .dbgRdData(dbgRdData), .regBank(regBank)
);

// File: tb/test_creg_access_unit.sv
module test_creg_access_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  privMode = 2'b00;
  logic        coreRdEn = 0, coreWrEn = 0, ovfClr = 0, coreMemEn = 0, dbgEn = 0, dbgWe = 0;
  logic [15:0] coreRdOfs = 0, coreWrOfs = 0, dbgOfs = 0;
  logic [31:0] coreWrData = 0, coreMemAddr = 0, dbgWrData = 0;
  logic [31:0] coreRdData, dbgRdData;
  logic        coreTrap, coreNoEffect, coreMemRefuse, dbgErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [31:0] mdl [16];

  always #4 clk = ~clk;

  creg_access_unit i_creg_access_unit (
    .clk(clk), .rstN(rstN), .privMode(privMode),
    .coreRdEn(coreRdEn), .coreRdOfs(coreRdOfs), .coreRdData(coreRdData),
    .coreWrEn(coreWrEn), .coreWrOfs(coreWrOfs), .coreWrData(coreWrData),
    .coreTrap(coreTrap), .coreNoEffect(coreNoEffect), .ovfClr(ovfClr),
    .coreMemEn(coreMemEn), .coreMemAddr(coreMemAddr), .coreMemRefuse(coreMemRefuse),
    .dbgEn(dbgEn), .dbgWe(dbgWe), .dbgOfs(dbgOfs), .dbgWrData(dbgWrData),
    .dbgRdData(dbgRdData), .dbgErr(dbgErr)
  );

  // Reference decode: slots 0..7 implemented, offset 0x0004 read-only
  function automatic bit refImpl(logic [15:0] ofs);
    return ofs[1:0] == 2'b00 && ofs < 16'h0020;
  endfunction
  function automatic bit refRo(logic [15:0] ofs);
    return ofs == 16'h0004;
  endfunction

  task automatic chk(string req, string ctx, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s (%s) %s: actual %h expected %h", req, ctx, what, act, exp);
    end
  endtask

  task automatic compareNow(string ctx);
    bit sup, trapE, ignE, commitE;
    sup     = privMode == 2'b10;
    trapE   = coreWrEn && !sup;
    commitE = coreWrEn && sup && refImpl(coreWrOfs) && !refRo(coreWrOfs);
    ignE    = coreWrEn && sup && !commitE;
    chk("R2", ctx, "coreTrap", 32'(coreTrap), 32'(trapE));
    chk("R4", ctx, "coreNoEffect", 32'(coreNoEffect), 32'(ignE));
    chk("R1", ctx, "coreRdData", coreRdData,
        (coreRdEn && refImpl(coreRdOfs)) ? mdl[coreRdOfs[5:2]] : 32'h0);
    chk("R8", ctx, "coreMemRefuse", 32'(coreMemRefuse),
        32'(coreMemEn && coreMemAddr[31:16] == 16'hF000));
    chk("R9", ctx, "dbgErr", 32'(dbgErr), 32'(dbgEn && dbgOfs[1:0] != 2'b00));
    chk("R9", ctx, "dbgRdData", dbgRdData,
        (dbgEn && !dbgWe && refImpl(dbgOfs)) ? mdl[dbgOfs[5:2]] : 32'h0);
  endtask

  task automatic updateModel();
    if (dbgEn && dbgWe && refImpl(dbgOfs) && !refRo(dbgOfs)) mdl[dbgOfs[5:2]] = dbgWrData;
    if (coreWrEn && privMode == 2'b10 && refImpl(coreWrOfs) && !refRo(coreWrOfs))
      mdl[coreWrOfs[5:2]] = coreWrData;
    if (ovfClr) mdl[0] = mdl[0] & 32'h07FF_FFFF;
  endtask

  task automatic tick(string ctx);
    #1 compareNow(ctx);
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic idle();
    coreRdEn = 0; coreWrEn = 0; ovfClr = 0; coreMemEn = 0; dbgEn = 0; dbgWe = 0;
  endtask

  task automatic coreWr(logic [1:0] pm, logic [15:0] ofs, logic [31:0] d, string ctx);
    idle(); privMode = pm; coreWrEn = 1; coreWrOfs = ofs; coreWrData = d; tick(ctx);
  endtask

  task automatic coreRd(logic [1:0] pm, logic [15:0] ofs, string ctx);
    idle(); privMode = pm; coreRdEn = 1; coreRdOfs = ofs; tick(ctx);
  endtask

  task automatic dbgAcc(logic we, logic [15:0] ofs, logic [31:0] d, string ctx);
    idle(); dbgEn = 1; dbgWe = we; dbgOfs = ofs; dbgWrData = d; tick(ctx);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = (i == 1) ? 32'hA5C3_0001 : 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R11: reset contents seen through both read paths
    for (int i = 0; i < 8; i++) coreRd(2'b00, 16'(i * 4), "R11 reset core read");
    for (int i = 0; i < 8; i++) dbgAcc(0, 16'(i * 4), 0, "R11 reset debug read");

    // R3: supervisor commits, then R1 reads in every mode
    for (int i = 0; i < 8; i++) coreWr(2'b10, 16'(i * 4), 32'h1357_0000 + 32'(i * 17), "R3 commit");
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++) coreRd(2'(m), 16'(i * 4), "R1 read any mode");

    // R2: user and reserved modes trap, nothing changes
    coreWr(2'b00, 16'h0008, 32'hDEAD_0001, "R2 user0");
    coreWr(2'b01, 16'h000C, 32'hDEAD_0002, "R2 user1");
    coreWr(2'b11, 16'h0010, 32'hDEAD_0003, "R2 reserved");
    coreWr(2'b01, 16'h0004, 32'hDEAD_0004, "R2 trap before read-only check");
    coreRd(2'b00, 16'h0008, "R2 readback");
    coreRd(2'b00, 16'h000C, "R2 readback");

    // R4: dropped supervisor writes
    coreWr(2'b10, 16'h0009, 32'hBAD0_0001, "R4 misaligned");
    coreWr(2'b10, 16'h0006, 32'hBAD0_0002, "R4 misaligned read-only");
    coreWr(2'b10, 16'h0004, 32'hBAD0_0003, "R4 read-only");
    coreWr(2'b10, 16'h0024, 32'hBAD0_0004, "R4 unimplemented");
    coreWr(2'b10, 16'h0100, 32'hBAD0_0005, "R4 far unimplemented");
    coreRd(2'b00, 16'h0008, "R4 readback");
    coreRd(2'b00, 16'h0004, "R4 readback read-only");

    // R5: undefined reads give zero
    coreRd(2'b10, 16'h0002, "R5 misaligned read");
    coreRd(2'b00, 16'h0030, "R5 unimplemented read");
    coreRd(2'b01, 16'h0200, "R5 far read");

    // R6: overflow clear in user mode, low bits kept
    coreWr(2'b10, 16'h0000, 32'hFFFF_FFFF, "R6 preset status");
    idle(); privMode = 2'b00; ovfClr = 1; tick("R6 clear");
    coreRd(2'b00, 16'h0000, "R6 readback");

    // R7: write and clear in the same cycle
    idle(); privMode = 2'b10; coreWrEn = 1; coreWrOfs = 16'h0000;
    coreWrData = 32'hF800_00A5; ovfClr = 1; tick("R7 write plus clear");
    coreRd(2'b00, 16'h0000, "R7 readback");

    // R8: window refusal
    idle(); coreMemEn = 1; coreMemAddr = 32'hF000_0008; tick("R8 in window");
    idle(); coreMemEn = 1; coreMemAddr = 32'hE000_0008; tick("R8 outside window");
    coreRd(2'b00, 16'h0008, "R8 readback");

    // R9: debug port
    dbgAcc(1, 16'h0014, 32'hD0D0_1234, "R9 debug write");
    dbgAcc(1, 16'h0004, 32'hD0D0_5678, "R9 debug read-only write");
    dbgAcc(1, 16'h0028, 32'hD0D0_9ABC, "R9 debug unimplemented write");
    dbgAcc(1, 16'h0013, 32'hD0D0_EEEE, "R9 debug misaligned write");
    dbgAcc(0, 16'h0011, 0, "R9 debug misaligned read");
    dbgAcc(0, 16'h0014, 0, "R9 debug readback");
    dbgAcc(0, 16'h0004, 0, "R9 debug read-only readback");
    coreRd(2'b00, 16'h0010, "R9 core readback");

    // R10: core beats debug on the same register
    idle(); privMode = 2'b10; coreWrEn = 1; coreWrOfs = 16'h0018; coreWrData = 32'hC0C0_0018;
    dbgEn = 1; dbgWe = 1; dbgOfs = 16'h0018; dbgWrData = 32'hDBDB_0018; tick("R10 collide");
    coreRd(2'b00, 16'h0018, "R10 readback");

    // Mixed bounded-random traffic
    for (int n = 0; n < 600; n++) begin
      idle();
      privMode    = 2'($urandom % 4);
      coreRdEn    = 1'($urandom % 2);
      coreRdOfs   = 16'($urandom % 72);
      coreWrEn    = 1'($urandom % 2);
      coreWrOfs   = 16'($urandom % 72);
      coreWrData  = $urandom;
      ovfClr      = ($urandom % 5) == 0;
      coreMemEn   = 1'($urandom % 2);
      coreMemAddr = (($urandom % 2) == 0) ? (32'hF000_0000 | 32'($urandom % 65536)) : $urandom;
      dbgEn       = 1'($urandom % 2);
      dbgWe       = 1'($urandom % 2);
      dbgOfs      = 16'($urandom % 72);
      dbgWrData   = $urandom;
      tick("mixed traffic");
    end
    idle();
    for (int i = 0; i < 8; i++) coreRd(2'b00, 16'(i * 4), "final readback");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule